// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level translation table stored in ordinary memory. A requester presents the virtual address, an access kind (read, write or execute) and the base address of the top-level table. The walker then fetches the top-level entry, follows it to the second-level table and fetches the leaf entry. It returns either the physical address together with the leaf's attribute bits, or a fault code.

Each translation that succeeds marks the leaf as referenced. A write also marks it as modified. The walker stores the updated leaf back to memory, but only when one of those two bits actually changes. Faults are only reported. Fetching a missing page or recovering from the fault belongs to the requester. Exactly one walk is in flight at any time, and the memory port tolerates any number of stall and wait cycles.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` is 0 and `rsp_valid` is 0.
- R2: The virtual address splits into a top-level index in bits [31:22], a second-level index in bits [21:12] and a byte offset in bits [11:0]. The first memory read is a read (`mem_req_write` = 0) at the table base plus 4 times the top-level index.
- R3: The second-level table base is taken from bits [31:12] of the top-level entry, with the low 12 bits zero. The second read goes to that base plus 4 times the second-level index.
- R4: When a translation succeeds, `rsp_fault` is 0 and `rsp_paddr` is leaf bits [31:12] followed by the unchanged 12-bit offset.
- R5: If bit 0 (valid) of the top-level entry is 0, the walk ends after one read with `rsp_fault` = 1 (not present).
- R6: If bit 0 of the leaf entry is 0, the walk ends with `rsp_fault` = 1 (not present). This check takes precedence over the permission check.
- R7: Access kind 0 (read) needs leaf bit 1, kind 1 (write) needs leaf bit 2 and kind 2 (execute) needs leaf bit 3. Kind 3 is always refused. A refusal gives `rsp_fault` = 2 (protection).
- R8: A successful access sets leaf bit 4 (referenced), and a write also sets leaf bit 5 (modified). The updated entry is written to the leaf's own address.
- R9: When bits 4 and 5 would not change, no memory write is issued.
- R10: A fault issues no memory write. It returns `rsp_paddr` = 0 and `rsp_attr` = 0.
- R11: On success, `rsp_attr` is bits [6:0] of the updated leaf. Bit 6 (cache disable) passes through unchanged.
- R12: `req_ready` is 0 from the accepted request until its response. `rsp_valid` is a single-cycle pulse. No memory request is raised while `req_ready` is 1.
- R13: A memory request that is not yet accepted keeps `mem_req_valid`, its address and its direction stable until `mem_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 refused |
| root_base | input | 32 | Top-level table base, sampled with the request |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for the write-back, 0 for entry reads |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated leaf entry for the write-back |
| mem_rsp_valid | input | 1 | Read data or write completion |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_attr | output | 7 | Updated leaf bits [6:0], 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The assertions assume that memory answers a request only after accepting it, with exactly one `mem_rsp_valid` pulse per accepted request. They also assume that the requester holds `req_vaddr`, `req_acc` and `root_base` steady in the cycle in which `req_valid` is sampled. The bench memory model keeps a single pending transaction, answers it after a random delay of zero to two cycles, and toggles `mem_req_ready` from a shift register so that requests stall. The driver raises `req_valid` only while `req_ready` is high, and only after the previous result has been consumed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int PTW_AW = 32;

  localparam int BIT_VALID = 0;
  localparam int BIT_RD    = 1;
  localparam int BIT_WR    = 2;
  localparam int BIT_EX    = 3;
  localparam int BIT_REF   = 4;
  localparam int BIT_MOD   = 5;
  localparam int ATTR_W    = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_DIR,
    ST_READ_PTE,
    ST_WRITEBACK,
    ST_DONE
  } walk_st_e;

  // entries are 4 bytes wide
  function automatic logic [PTW_AW-1:0] entry_addr(input logic [PTW_AW-1:0] base,
                                                   input logic [PTW_AW-1:0] idx);
    return base + (idx << 2);
  endfunction

  function automatic logic perm_ok(input logic [PTW_AW-1:0] ent, input acc_e acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = ent[BIT_RD];
      ACC_WRITE: ok = ent[BIT_WR];
      ACC_EXEC:  ok = ent[BIT_EX];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [PTW_AW-1:0] mark_entry(input logic [PTW_AW-1:0] ent,
                                                   input acc_e acc);
    logic [PTW_AW-1:0] e;
    e = ent;
    e[BIT_REF] = 1'b1;
    if (acc == ACC_WRITE) e[BIT_MOD] = 1'b1;
    return e;
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10
) (
  input  logic [PTW_AW-1:0]          vaddr,
  input  logic [PTW_AW-1:0]          root_base,
  input  logic [DIR_BITS+TBL_BITS-1:0] tbl_base,
  output logic [PTW_AW-1:0]          dir_addr,
  output logic [PTW_AW-1:0]          pte_addr
);
  localparam int OFF_BITS = PTW_AW - DIR_BITS - TBL_BITS;

  logic [PTW_AW-1:0] dir_idx;
  logic [PTW_AW-1:0] tbl_idx;
  logic [PTW_AW-1:0] tbl_base_full;

  assign dir_idx       = PTW_AW'(vaddr[PTW_AW-1 -: DIR_BITS]);
  assign tbl_idx       = PTW_AW'(vaddr[OFF_BITS +: TBL_BITS]);
  assign tbl_base_full = {tbl_base, {OFF_BITS{1'b0}}};

  assign dir_addr = entry_addr(root_base, dir_idx);
  assign pte_addr = entry_addr(tbl_base_full, tbl_idx);
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
(
  input  logic [PTW_AW-1:0] pte,
  input  acc_e              acc,
  output flt_e              fault,
  output logic [PTW_AW-1:0] upd_entry,
  output logic              need_wb
);
  always_comb begin
    upd_entry = mark_entry(pte, acc);
    if (!pte[BIT_VALID])          fault = FLT_ABSENT;
    else if (!perm_ok(pte, acc))  fault = FLT_PROT;
    else                          fault = FLT_NONE;
    need_wb = (upd_entry != pte);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [31:0]         req_vaddr,
  input  logic [1:0]          req_acc,
  input  logic [31:0]         root_base,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [31:0]         mem_req_addr,
  output logic [31:0]         mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_rdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_paddr,
  output logic [6:0]          rsp_attr,
  output logic [1:0]          rsp_fault
);
  localparam int OFF_BITS = PTW_AW - DIR_BITS - TBL_BITS;
  localparam int PPN_BITS = DIR_BITS + TBL_BITS;

  walk_st_e              state_q;
  logic [PTW_AW-1:0]     vaddr_q;
  logic [PTW_AW-1:0]     root_q;
  acc_e                  acc_q;
  logic [PPN_BITS-1:0]   tbl_base_q;
  logic                  issued_q;
  flt_e                  fault_q;
  logic [PTW_AW-1:0]     paddr_q;
  logic [ATTR_W-1:0]     attr_q;
  logic [PTW_AW-1:0]     wb_entry_q;

  logic [PTW_AW-1:0]     dir_addr;
  logic [PTW_AW-1:0]     pte_addr;
  flt_e                  leaf_fault;
  logic [PTW_AW-1:0]     leaf_upd;
  logic                  leaf_need_wb;

  // named events for the checker
  logic                  mem_hs;
  logic                  mem_done;
  logic [OFF_BITS-1:0]   walk_off;

  assign mem_hs   = mem_req_valid && mem_req_ready;
  assign mem_done = issued_q && mem_rsp_valid;
  assign walk_off = vaddr_q[OFF_BITS-1:0];

  ptw_addr_gen #(.DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS)) u_addr (
    .vaddr     (vaddr_q),
    .root_base (root_q),
    .tbl_base  (tbl_base_q),
    .dir_addr  (dir_addr),
    .pte_addr  (pte_addr)
  );

  ptw_leaf_eval u_leaf (
    .pte       (mem_rsp_rdata),
    .acc       (acc_q),
    .fault     (leaf_fault),
    .upd_entry (leaf_upd),
    .need_wb   (leaf_need_wb)
  );

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (state_q)
      ST_READ_DIR: begin
        mem_req_valid = !issued_q;
        mem_req_addr  = dir_addr;
      end
      ST_READ_PTE: begin
        mem_req_valid = !issued_q;
        mem_req_addr  = pte_addr;
      end
      ST_WRITEBACK: begin
        mem_req_valid = !issued_q;
        mem_req_write = 1'b1;
        mem_req_addr  = pte_addr;
        mem_req_wdata = wb_entry_q;
      end
      default: ;
    endcase
    rsp_valid = (state_q == ST_DONE);
    rsp_paddr = paddr_q;
    rsp_attr  = attr_q;
    rsp_fault = fault_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vaddr_q    <= '0;
      root_q     <= '0;
      acc_q      <= ACC_READ;
      tbl_base_q <= '0;
      issued_q   <= 1'b0;
      fault_q    <= FLT_NONE;
      paddr_q    <= '0;
      attr_q     <= '0;
      wb_entry_q <= '0;
    end else begin
      if (mem_hs) issued_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q  <= req_vaddr;
            root_q   <= root_base;
            acc_q    <= acc_e'(req_acc);
            issued_q <= 1'b0;
            fault_q  <= FLT_NONE;
            paddr_q  <= '0;
            attr_q   <= '0;
            state_q  <= ST_READ_DIR;
          end
        end
        ST_READ_DIR: begin
          if (mem_done) begin
            issued_q   <= 1'b0;
            tbl_base_q <= mem_rsp_rdata[PTW_AW-1:OFF_BITS];
            if (!mem_rsp_rdata[BIT_VALID]) begin
              fault_q <= FLT_ABSENT;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_READ_PTE;
            end
          end
        end
        ST_READ_PTE: begin
          if (mem_done) begin
            issued_q <= 1'b0;
            if (leaf_fault != FLT_NONE) begin
              fault_q <= leaf_fault;
              state_q <= ST_DONE;
            end else begin
              paddr_q    <= {mem_rsp_rdata[PTW_AW-1:OFF_BITS], walk_off};
              attr_q     <= leaf_upd[ATTR_W-1:0];
              wb_entry_q <= leaf_upd;
              state_q    <= leaf_need_wb ? ST_WRITEBACK : ST_DONE;
            end
          end
        end
        ST_WRITEBACK: begin
          if (mem_done) begin
            issued_q <= 1'b0;
            state_q  <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int OFF_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic                mem_req_write,
  input logic [31:0]         mem_req_addr,
  input logic [31:0]         mem_req_wdata,
  input logic                rsp_valid,
  input logic [31:0]         rsp_paddr,
  input logic [6:0]          rsp_attr,
  input logic [1:0]          rsp_fault,
  input logic [OFF_BITS-1:0] walk_off
);
  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_BITS-1:0] == walk_off));

  a_r8_ref_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> rsp_attr[4]);

  a_r8_wb_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[4] && mem_req_wdata[0]));

  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0 && rsp_attr == 7'd0));

  a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'd3));
endmodule

bind ptw_walker ptw_walker_chk #(.OFF_BITS(OFF_BITS)) u_ptw_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_attr      (rsp_attr),
  .rsp_fault     (rsp_fault),
  .walk_off      (walk_off)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [31:0] root_base = ROOT;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [6:0]  rsp_attr;
  logic [1:0]  rsp_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
    .rsp_fault(rsp_fault)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem [0:4095];
  logic        hs = 1'b0;
  logic [31:0] hs_addr = '0;
  logic        hs_wr = 1'b0;
  logic [31:0] hs_wd = '0;
  int          nreads = 0;
  int          nwrites = 0;
  logic [31:0] rd_log [0:1];
  logic [7:0]  lfsr = 8'hA5;

  always @(posedge clk) begin
    hs      <= mem_req_valid && mem_req_ready;
    hs_addr <= mem_req_addr;
    hs_wr   <= mem_req_write;
    hs_wd   <= mem_req_wdata;
  end

  initial begin
    bit          pend = 0;
    int          dly = 0;
    logic [31:0] p_addr = '0;
    logic        p_wr = 0;
    logic [31:0] p_wd = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs) begin
        pend = 1; dly = int'(lfsr[1:0]) % 3;
        p_addr = hs_addr; p_wr = hs_wr; p_wd = hs_wd;
      end
      if (pend) begin
        if (dly == 0) begin
          pend = 0;
          mem_rsp_valid = 1'b1;
          if (p_wr) begin
            mem[p_addr[13:2]] = p_wd;
            nwrites++;
          end else begin
            mem_rsp_rdata = mem[p_addr[13:2]];
            if (nreads < 2) rd_log[nreads] = p_addr;
            nreads++;
          end
        end else dly--;
      end
      mem_req_ready = lfsr[0] | lfsr[3];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string       tag;
    logic [31:0] paddr;
    logic [6:0]  attr;
    logic [1:0]  fault;
    int          exp_reads;
    int          exp_writes;
    logic [31:0] dir_a;
    logic [31:0] pte_a;
    logic [31:0] leaf_after;
  } item_t;

  item_t sb_q[$];

  // independent reference model computed from the requirements
  task automatic model(input logic [31:0] va, input logic [1:0] acc, input string tag,
                       output item_t it);
    logic [31:0] de, pe, ne;
    logic        allow;
    it.tag = tag; it.paddr = '0; it.attr = '0; it.fault = 2'd0;
    it.exp_writes = 0; it.pte_a = '0; it.leaf_after = '0;
    it.dir_a = ROOT + {20'd0, va[31:22], 2'b00};
    de = mem[it.dir_a[13:2]];
    if (!de[0]) begin
      it.fault = 2'd1; it.exp_reads = 1;
      return;
    end
    it.exp_reads = 2;
    it.pte_a = {de[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
    pe = mem[it.pte_a[13:2]];
    it.leaf_after = pe;
    if (!pe[0]) begin it.fault = 2'd1; return; end
    case (acc)
      2'd0: allow = pe[1];
      2'd1: allow = pe[2];
      2'd2: allow = pe[3];
      default: allow = 1'b0;
    endcase
    if (!allow) begin it.fault = 2'd2; return; end
    ne = pe | 32'h10 | ((acc == 2'd1) ? 32'h20 : 32'h0);
    it.leaf_after = ne;
    it.exp_writes = (ne != pe) ? 1 : 0;
    it.paddr = {pe[31:12], va[11:0]};
    it.attr  = ne[6:0];
  endtask

  task automatic drive(input logic [9:0] d, input logic [9:0] t, input logic [11:0] off,
                       input logic [1:0] acc, input string tag);
    item_t it;
    logic [31:0] va;
    va = {d, t, off};
    model(va, acc, tag, it);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nreads = 0; nwrites = 0;
    sb_q.push_back(it);
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = 32'hDEAD_BEEF;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (sb_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R12 actual=unexpected response expected=none");
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check({it.tag, " R4 paddr"}, rsp_paddr, it.paddr);
          check({it.tag, " R11 attr"}, {25'd0, rsp_attr}, {25'd0, it.attr});
          check({it.tag, " fault"}, {30'd0, rsp_fault}, {30'd0, it.fault});
          check({it.tag, " reads"}, nreads, it.exp_reads);
          check({it.tag, " R9 writes"}, nwrites, it.exp_writes);
          check({it.tag, " R2 dir addr"}, rd_log[0], it.dir_a);
          if (it.exp_reads == 2) begin
            check({it.tag, " R3 leaf addr"}, rd_log[1], it.pte_a);
            check({it.tag, " R8 leaf in memory"}, mem[it.pte_a[13:2]], it.leaf_after);
          end
          @(negedge clk);
          check({it.tag, " R12 pulse"}, {31'd0, rsp_valid}, 32'd0);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[(32'h1000 >> 2) + 0]   = 32'h0000_2001;  // dir 0 -> table 0x2000
    mem[(32'h1000 >> 2) + 5]   = 32'h0000_3001;  // dir 5 -> table 0x3000
    mem[(32'h1000 >> 2) + 9]   = 32'h0000_3000;  // dir 9 invalid
    mem[(32'h2000 >> 2) + 0]   = 32'hABCD_E003;  // read only
    mem[(32'h2000 >> 2) + 1]   = 32'h1234_5007;  // read/write
    mem[(32'h2000 >> 2) + 2]   = 32'h5555_5006;  // invalid leaf with perms
    mem[(32'h2000 >> 2) + 3]   = 32'h7777_7009;  // execute only
    mem[(32'h2000 >> 2) + 4]   = 32'h0FED_C077;  // rw, ref+mod already, cache off
    mem[(32'h3000 >> 2) + 1023] = 32'hFFFF_F00F; // all perms

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;

    drive(10'd0, 10'd0, 12'h123, 2'd0, "R4 R8 read sets ref");
    drive(10'd0, 10'd0, 12'hFFF, 2'd0, "R9 repeat read no wb");
    drive(10'd0, 10'd1, 12'h000, 2'd1, "R8 write sets mod");
    drive(10'd0, 10'd0, 12'h456, 2'd1, "R7 write to read-only");
    drive(10'd9, 10'd3, 12'h010, 2'd0, "R5 dir invalid");
    drive(10'd600, 10'd0, 12'h010, 2'd2, "R5 empty dir slot");
    drive(10'd0, 10'd2, 12'h020, 2'd0, "R6 leaf invalid");
    drive(10'd0, 10'd3, 12'h7A8, 2'd0, "R7 read of exec-only");
    drive(10'd0, 10'd3, 12'h7A8, 2'd2, "R7 exec allowed");
    drive(10'd0, 10'd4, 12'hABC, 2'd1, "R11 cache-disable kept");
    drive(10'd5, 10'd1023, 12'h001, 2'd3, "R7 reserved kind refused");
    drive(10'd5, 10'd1023, 12'hEEE, 2'd1, "R3 second table");
    drive(10'd0, 10'd1, 12'h3C4, 2'd1, "R9 write again no wb");

    repeat (3) @(negedge clk);
    check("R10 leaf untouched after fault", mem[(32'h2000 >> 2) + 2], 32'h5555_5006);
    check("R12 idle after run", {31'd0, req_ready}, 32'd1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule